// File: doc/BRIEF.md
# SPI Slave Serial Front End with Hold

This block is the bit-level front end of a flash-style SPI slave. It runs from the system clock and oversamples the serial pins through synchronizers. It works in both clock polarities: SCK idling low (mode 0) or high (mode 3). Data-in bits are taken on SCK rising edges, most significant bit first, and each group of eight is handed to the command logic as one strobed byte, together with its position since chip select fell. For outgoing data the command logic answers a per-byte request by loading a parallel byte. The block shifts that byte out on the following SCK falling edges and drives the output enable for the data-output pad.

A hold input can pause a transfer without losing its place. Hold entry and exit take effect only while SCK is low. While the transfer is held, the output is released and all SCK and data-in activity is ignored. If chip select rises partway through a byte, or while the transfer is held, the transfer is cut short: an abort pulse is raised and all transfer state is cleared. Opcode decoding lives outside this block.

Top module: `spi_hold_front`

## Requirements
- R1: While chip select is low and the transfer is not held, mosi is sampled on each SCK rising edge, MSB first. On the 8th bit a one-cycle rx_valid pulse presents rx_data and rx_index. rx_index is 0 for the first byte after chip select falls and rises by one per byte.
- R2: A byte loaded through tx_load is moved into the output shifter on the first SCK falling edge after a completed byte (never before the first byte). It appears on miso MSB first and advances one bit per falling edge, so the master reads it on its rising edges. This holds in mode 0 and in mode 3.
- R3: tx_req pulses for one cycle each time a byte completes, so there is one pulse per received byte.
- R4: miso_oe is high only while chip select is low, the transfer is not held and a loaded byte is being shifted. If no byte was loaded at a byte boundary, miso_oe stays low for that byte.
- R5: Hold is entered when hold_n is low and SCK is low. If hold_n falls while SCK is high, hold_active rises only after SCK next goes low.
- R6: Hold is left when hold_n is high and SCK is low. If hold_n rises while SCK is high, hold_active falls only after SCK next goes low.
- R7: While held, SCK edges and mosi are ignored, no byte is produced, and the bit and byte counts are kept. After hold ends, the byte under way completes with the correct value and the correct output bits.
- R8: If chip select rises with a partial byte or while held, abort pulses for one cycle, hold_active clears, and the next transfer starts again at index 0 with a fresh bit count.
- R9: If chip select rises exactly on a byte boundary while not held, no abort pulse is produced.
- R10: hold_n has no effect while chip select is high.
- R11: After reset, miso_oe, hold_active, rx_valid, tx_req and abort are all low.
- R12: In mode 3, the SCK falling edge that precedes the first rising edge of a transfer does not disturb the bit count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low, asynchronous |
| sck | input | 1 | Serial clock, asynchronous |
| mosi | input | 1 | Serial data in |
| hold_n | input | 1 | Hold request, active low |
| tx_data | input | BITS | Parallel byte to transmit |
| tx_load | input | 1 | Writes tx_data into the transmit buffer |
| rx_valid | output | 1 | One-cycle strobe for a received byte |
| rx_data | output | BITS | Received byte |
| rx_index | output | IDX_W | Byte position since chip select fell |
| tx_req | output | 1 | Request for the next transmit byte |
| miso | output | 1 | Serial data out |
| miso_oe | output | 1 | Output enable for the miso pad |
| abort | output | 1 | Transfer cut short by chip select |
| hold_active | output | 1 | Transfer currently held |

## Verification
The assertions assume that the serial pins change slowly compared with clk. Every SCK level and every hold_n level must last several system cycles, so the synchronizers see each edge as a separate event. They also assume that tx_load and a chip-select rise do not land in the same cycle. The stimulus holds every SCK phase for eight system clocks and changes pins only on falling clk edges. It toggles hold_n and chip select only while SCK has been stable for at least half a bit time, and it loads the transmit byte well before the byte boundary.

// File: rtl/sfe_pkg.sv
package sfe_pkg;
  localparam int SFE_SYNC_STAGES = 2;

  // next hold state: changes only while selected and SCK is low
  function automatic logic hold_next(input logic sel, input logic held,
                                     input logic hold_lvl, input logic sck_lvl);
    logic n;
    n = held;
    if (!sel) n = 1'b0;
    else if (!sck_lvl) n = !hold_lvl;
    return n;
  endfunction
endpackage

// File: rtl/sfe_sync.sv
module sfe_sync #(
  parameter int          W       = 4,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) pipe[g] <= RST_VAL;
        else     pipe[g] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) pipe[g] <= RST_VAL;
        else     pipe[g] <= pipe[g-1];
      end
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/sfe_events.sv
module sfe_events #(
  parameter int STAGES = sfe_pkg::SFE_SYNC_STAGES
) (
  input  logic clk,
  input  logic rst,
  input  logic cs_n,
  input  logic sck,
  input  logic mosi,
  input  logic hold_n,
  output logic sel,
  output logic sel_start,
  output logic sel_end,
  output logic sck_rise,
  output logic sck_fall,
  output logic mosi_s,
  output logic held,
  output logic hold_nxt
);
  logic [3:0] raw, syn;
  logic cs_s, sck_s, hold_s;
  logic cs_q, sck_q;

  assign raw = {hold_n, mosi, sck, cs_n};

  sfe_sync #(.W(4), .STAGES(STAGES), .RST_VAL(4'b1001)) u_sync (
    .clk(clk), .rst(rst), .d(raw), .q(syn)
  );

  assign cs_s   = syn[0];
  assign sck_s  = syn[1];
  assign mosi_s = syn[2];
  assign hold_s = syn[3];

  assign sel       = !cs_s;
  assign sel_start = cs_q && !cs_s;
  assign sel_end   = !cs_q && cs_s;
  // edges only count while selected and not held
  assign sck_rise  = sel && !held && sck_s && !sck_q;
  assign sck_fall  = sel && !held && !sck_s && sck_q;
  assign hold_nxt  = sfe_pkg::hold_next(sel, held, hold_s, sck_s);

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_q  <= 1'b1;
      sck_q <= 1'b0;
      held  <= 1'b0;
    end else begin
      cs_q  <= cs_s;
      sck_q <= sck_s;
      held  <= hold_nxt;
    end
  end
endmodule

// File: rtl/sfe_rx.sv
module sfe_rx #(
  parameter int BITS  = 8,
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sel_start,
  input  logic             sel_end,
  input  logic             sck_rise,
  input  logic             mosi_s,
  input  logic             held,
  output logic             rx_valid,
  output logic [BITS-1:0]  rx_data,
  output logic [IDX_W-1:0] rx_index,
  output logic             tx_req,
  output logic             abort,
  output logic             at_boundary,
  output logic             in_first
);
  localparam int            CW   = $clog2(BITS);
  localparam logic [CW-1:0] LAST = CW'(BITS - 1);

  logic [CW-1:0]    bit_cnt;
  logic [IDX_W-1:0] byte_cnt;
  logic [BITS-1:0]  shreg;
  logic [BITS-1:0]  sh_in;

  assign sh_in       = {shreg[BITS-2:0], mosi_s};
  assign at_boundary = (bit_cnt == '0);
  assign in_first    = (byte_cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_cnt  <= '0;
      byte_cnt <= '0;
      shreg    <= '0;
      rx_valid <= 1'b0;
      rx_data  <= '0;
      rx_index <= '0;
      tx_req   <= 1'b0;
      abort    <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      tx_req   <= 1'b0;
      abort    <= 1'b0;
      if (sel_start || sel_end) begin
        bit_cnt  <= '0;
        byte_cnt <= '0;
        abort    <= sel_end && ((bit_cnt != '0) || held);
      end else if (sck_rise) begin
        shreg <= sh_in;
        if (bit_cnt == LAST) begin
          bit_cnt  <= '0;
          byte_cnt <= byte_cnt + 1'b1;
          rx_valid <= 1'b1;
          rx_data  <= sh_in;
          rx_index <= byte_cnt;
          tx_req   <= 1'b1;
        end else begin
          bit_cnt <= bit_cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sfe_tx.sv
module sfe_tx #(
  parameter int BITS = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            sel,
  input  logic            sel_end,
  input  logic            sck_fall,
  input  logic            hold_nxt,
  input  logic            at_boundary,
  input  logic            in_first,
  input  logic [BITS-1:0] tx_data,
  input  logic            tx_load,
  output logic            miso,
  output logic            miso_oe
);
  logic [BITS-1:0] buf_q, buf_n, sh_q, sh_n;
  logic            full_q, full_n, live_q, live_n, oe_n;

  always_comb begin
    buf_n  = buf_q;
    full_n = full_q;
    sh_n   = sh_q;
    live_n = live_q;
    if (sel_end) begin
      full_n = 1'b0;
      live_n = 1'b0;
      sh_n   = '0;
    end else if (sck_fall) begin
      if (at_boundary && !in_first) begin
        if (full_q) begin
          sh_n   = buf_q;
          live_n = 1'b1;
          full_n = 1'b0;
        end else begin
          live_n = 1'b0;
        end
      end else begin
        sh_n = {sh_q[BITS-2:0], 1'b0};
      end
    end
    if (tx_load) begin
      buf_n  = tx_data;
      full_n = 1'b1;
    end
    oe_n = sel && !hold_nxt && live_n;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      buf_q   <= '0;
      full_q  <= 1'b0;
      sh_q    <= '0;
      live_q  <= 1'b0;
      miso_oe <= 1'b0;
    end else begin
      buf_q   <= buf_n;
      full_q  <= full_n;
      sh_q    <= sh_n;
      live_q  <= live_n;
      miso_oe <= oe_n;
    end
  end

  assign miso = sh_q[BITS-1];
endmodule

// File: rtl/spi_hold_front.sv
module spi_hold_front #(
  parameter int BITS        = 8,
  parameter int IDX_W       = 8,
  parameter int SYNC_STAGES = sfe_pkg::SFE_SYNC_STAGES
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cs_n,
  input  logic             sck,
  input  logic             mosi,
  input  logic             hold_n,
  input  logic [BITS-1:0]  tx_data,
  input  logic             tx_load,
  output logic             rx_valid,
  output logic [BITS-1:0]  rx_data,
  output logic [IDX_W-1:0] rx_index,
  output logic             tx_req,
  output logic             miso,
  output logic             miso_oe,
  output logic             abort,
  output logic             hold_active
);
  logic sel, sel_start, sel_end, sck_rise, sck_fall, mosi_s, held, hold_nxt;
  logic at_boundary, in_first;

  sfe_events #(.STAGES(SYNC_STAGES)) u_ev (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .mosi(mosi), .hold_n(hold_n),
    .sel(sel), .sel_start(sel_start), .sel_end(sel_end),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .mosi_s(mosi_s),
    .held(held), .hold_nxt(hold_nxt)
  );

  sfe_rx #(.BITS(BITS), .IDX_W(IDX_W)) u_rx (
    .clk(clk), .rst(rst), .sel_start(sel_start), .sel_end(sel_end),
    .sck_rise(sck_rise), .mosi_s(mosi_s), .held(held),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_index(rx_index),
    .tx_req(tx_req), .abort(abort),
    .at_boundary(at_boundary), .in_first(in_first)
  );

  sfe_tx #(.BITS(BITS)) u_tx (
    .clk(clk), .rst(rst), .sel(sel), .sel_end(sel_end), .sck_fall(sck_fall),
    .hold_nxt(hold_nxt), .at_boundary(at_boundary), .in_first(in_first),
    .tx_data(tx_data), .tx_load(tx_load), .miso(miso), .miso_oe(miso_oe)
  );

  assign hold_active = held;
endmodule

// File: rtl/spi_hold_front_chk.sv
module spi_hold_front_chk (
  input logic clk,
  input logic rst,
  input logic rx_valid,
  input logic miso_oe,
  input logic abort,
  input logic hold_active
);
  AST_RX_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid); // R1
  AST_NO_OE_WHILE_HELD: assert property (@(posedge clk) disable iff (rst)
    hold_active |-> !miso_oe); // R4
  AST_NO_RX_AFTER_HELD: assert property (@(posedge clk) disable iff (rst)
    hold_active |=> !rx_valid); // R7
  AST_ABORT_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
    abort |=> !abort); // R8
  AST_ABORT_CLEARS_HOLD: assert property (@(posedge clk) disable iff (rst)
    abort |-> (!hold_active && !rx_valid && !miso_oe)); // R8
endmodule

bind spi_hold_front spi_hold_front_chk u_chk (
  .clk(clk), .rst(rst), .rx_valid(rx_valid), .miso_oe(miso_oe),
  .abort(abort), .hold_active(hold_active)
);

// File: tb/tb_spi_hold_front.sv
`timescale 1ns/1ps
module tb_spi_hold_front;
  localparam int H = 8;  // system clocks per SCK phase

  logic clk = 1'b0, rst = 1'b1;
  logic cs_n = 1'b1, sck = 1'b0, mosi = 1'b0, hold_n = 1'b1;
  logic [7:0] tx_data = 8'h00;
  logic tx_load = 1'b0;
  logic rx_valid, tx_req, miso, miso_oe, abort, hold_active;
  logic [7:0] rx_data, rx_index;

  always #4 clk = ~clk;

  spi_hold_front dut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .mosi(mosi), .hold_n(hold_n),
    .tx_data(tx_data), .tx_load(tx_load), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_index(rx_index), .tx_req(tx_req), .miso(miso), .miso_oe(miso_oe),
    .abort(abort), .hold_active(hold_active)
  );

  int checks = 0, failures = 0;
  bit done = 0;
  int rx_n = 0, abort_n = 0, req_n = 0, oe_n = 0;
  logic [7:0] rx_log [32];
  logic [7:0] idx_log [32];

  always @(negedge clk) begin
    if (!rst) begin
      if (rx_valid) begin
        rx_log[rx_n % 32]  <= rx_data;
        idx_log[rx_n % 32] <= rx_index;
        rx_n <= rx_n + 1;
      end
      if (abort) abort_n <= abort_n + 1;
      if (tx_req) req_n <= req_n + 1;
      if (miso_oe) oe_n <= oe_n + 1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_xfer(input logic b, output logic so, output logic oe);
    sck = 1'b0; mosi = b;
    waitc(H);
    so = miso; oe = miso_oe;
    sck = 1'b1;
    waitc(H);
  endtask

  task automatic byte_xfer(input logic [7:0] b, output logic [7:0] so, output int oe_cnt);
    logic s, o;
    oe_cnt = 0;
    for (int i = 7; i >= 0; i--) begin
      bit_xfer(b[i], s, o);
      so[i] = s;
      if (o) oe_cnt++;
    end
  endtask

  task automatic start(input logic mode);
    sck = mode; waitc(4);
    cs_n = 1'b0; waitc(4);
  endtask

  task automatic stop(input logic mode);
    if (!mode) begin sck = 1'b0; waitc(H); end
    cs_n = 1'b1; waitc(H);
  endtask

  task automatic load(input logic [7:0] v);
    tx_data = v; tx_load = 1'b1;
    waitc(1);
    tx_load = 1'b0;
  endtask

  // {mode, byte0, byte1, tx byte}
  localparam logic [24:0] VEC [6] = '{
    {1'b0, 8'hA5, 8'h3C, 8'hC3},
    {1'b1, 8'h5A, 8'h81, 8'h7E},
    {1'b0, 8'hFF, 8'h00, 8'h96},
    {1'b1, 8'h00, 8'hFF, 8'h01},
    {1'b0, 8'h80, 8'h01, 8'h80},
    {1'b1, 8'h13, 8'hEC, 8'hF0}
  };

  initial begin
    waitc(300000);
    checks++; failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    logic [7:0] so0, so1;
    int oc0, oc1, base, ab0, rq0, oe0;
    logic s, o;

    waitc(5);
    rst = 1'b0;
    waitc(2);
    // R11 reset state
    chk("R11 oe", miso_oe, 0);
    chk("R11 hold", hold_active, 0);
    chk("R11 strobes", {rx_valid, tx_req, abort}, 0);

    // vector table
    foreach (VEC[v]) begin
      base = rx_n; ab0 = abort_n; rq0 = req_n;
      start(VEC[v][24]);
      load(VEC[v][7:0]);
      byte_xfer(VEC[v][23:16], so0, oc0);
      byte_xfer(VEC[v][15:8], so1, oc1);
      stop(VEC[v][24]);
      chk("R1 count", rx_n - base, 2);
      chk("R1/R12 byte0", rx_log[base % 32], VEC[v][23:16]);
      chk("R1 idx0", idx_log[base % 32], 0);
      chk("R1 byte1", rx_log[(base + 1) % 32], VEC[v][15:8]);
      chk("R1 idx1", idx_log[(base + 1) % 32], 1);
      chk("R2 miso byte", so1, VEC[v][7:0]);
      chk("R4 oe byte1", oc1, 8);
      chk("R4 oe byte0", oc0, 0);
      chk("R3 tx_req", req_n - rq0, 2);
      chk("R9 no abort", abort_n - ab0, 0);
    end

    // R4: no byte loaded -> output stays disabled
    oe0 = oe_n;
    start(1'b0);
    byte_xfer(8'h11, so0, oc0);
    byte_xfer(8'h22, so1, oc1);
    stop(1'b0);
    chk("R4 no load oe", oe_n - oe0, 0);

    // R5/R6/R7: hold with SCK low inside byte1 while shifting
    base = rx_n;
    start(1'b0);
    load(8'hB6);
    byte_xfer(8'h4D, so0, oc0);
    so1 = 8'h00;
    for (int i = 7; i >= 5; i--) begin bit_xfer(i[0], s, o); so1[i] = s; end
    sck = 1'b0; waitc(H);
    hold_n = 1'b0; waitc(6);
    chk("R5 hold enter", hold_active, 1);
    chk("R4 oe held", miso_oe, 0);
    for (int k = 0; k < 3; k++) begin
      sck = 1'b1; mosi = ~mosi; waitc(H);
      sck = 1'b0; waitc(H);
    end
    chk("R7 no rx in hold", rx_n - base, 1);
    hold_n = 1'b1; waitc(6);
    chk("R6 hold exit", hold_active, 0);
    chk("R4 oe resumes", miso_oe, 1);
    for (int i = 4; i >= 0; i--) begin bit_xfer(i[0], s, o); so1[i] = s; end
    stop(1'b0);
    chk("R7 byte intact", rx_log[(base + 1) % 32], 8'b10101010);
    chk("R7 index kept", idx_log[(base + 1) % 32], 1);
    chk("R7 miso intact", so1, 8'hB6);

    // R5/R6 delayed by SCK high, during byte0 in mode 3
    base = rx_n;
    start(1'b1);
    for (int i = 7; i >= 4; i--) bit_xfer(1'b1, s, o);
    hold_n = 1'b0; waitc(6);
    chk("R5 wait for sck low", hold_active, 0);
    sck = 1'b0; waitc(6);
    chk("R5 delayed enter", hold_active, 1);
    sck = 1'b1; mosi = 1'b0; waitc(H);
    hold_n = 1'b1; waitc(6);
    chk("R6 wait for sck low", hold_active, 1);
    sck = 1'b0; waitc(6);
    chk("R6 delayed exit", hold_active, 0);
    for (int i = 3; i >= 0; i--) bit_xfer(1'b0, s, o);
    stop(1'b1);
    chk("R7 byte after hold", rx_log[base % 32], 8'hF0);

    // R8: chip select rises mid-byte
    ab0 = abort_n; base = rx_n;
    start(1'b0);
    for (int i = 0; i < 3; i++) bit_xfer(1'b1, s, o);
    stop(1'b0);
    chk("R8 abort mid byte", abort_n - ab0, 1);
    start(1'b0);
    byte_xfer(8'h69, so0, oc0);
    stop(1'b0);
    chk("R8 fresh byte", rx_log[base % 32], 8'h69);
    chk("R8 fresh index", idx_log[base % 32], 0);

    // R8: chip select rises while held at a boundary
    ab0 = abort_n;
    start(1'b0);
    byte_xfer(8'h77, so0, oc0);
    sck = 1'b0; waitc(H);
    hold_n = 1'b0; waitc(6);
    chk("R5 held at boundary", hold_active, 1);
    cs_n = 1'b1; waitc(H);
    chk("R8 abort in hold", abort_n - ab0, 1);
    chk("R8 hold cleared", hold_active, 0);

    // R10: hold_n ignored while deselected
    waitc(H);
    chk("R10 hold ignored", hold_active, 0);
    hold_n = 1'b1; waitc(H);

    finish_run();
  end
endmodule